// File: doc/BRIEF.md
# Bank-Gated Associative Cache Array

This block is the data and tag store of a low-power cache. A request's virtual address is decoded first. That decode picks one of several banks, and only that bank is switched on for the lookup. Inside the chosen bank every line is a candidate. A bank is one fully associative set, so the array as a whole is highly associative. With the default sizes, 16 KB is split into 16 banks of 32 lines each, and each line is 32 bytes.

A read is a two-step operation. In the request cycle the bank index is registered. In the next cycle the chosen bank is powered and compared against a physical tag, which is supplied only at that point. The result is registered for the cycle after that.

A single write channel carries either a whole-line refill or a one-word update. The refill goes into a round-robin victim. The word update is applied only on a tag hit. A write may proceed in the same cycle as a read when the two use different banks. When they use the same bank, the write wins and the read waits one cycle. The per-bank enable strobes are brought out so that activity can be observed.

Top module: `bgate_cache`

## Requirements
- R1: After reset no line is valid, so every read reports a miss with zero data. While no access is in progress, `bank_en` is all zero and `rd_busy` and `rd_done` are low.
- R2: Address fields:
  - bits [8:5] of an address select the bank;
  - bits [4:2] select the 32-bit word within the line;
  - bits [1:0] and bits above 8 have no effect.
- R3: Read timing:
  - a read is accepted in cycle N when `rd_req` is high and `rd_busy` is low;
  - `rd_ptag` is sampled in cycle N+1;
  - `rd_done` is high for one cycle in N+2, unless the read is stalled.
- R4: A read hits when a valid line in its bank holds a tag equal to `rd_ptag`. On a hit, `rd_data` is the addressed word. If several lines match, the lowest-numbered way supplies the data. On a miss, `rd_hit` is 0 and `rd_data` is 0.
- R5: In the lookup cycle of a read, `bank_en` has exactly the bit of the read's bank set, plus the bit of a concurrent write's bank if there is one.
- R6: A write accepted in the same cycle as a read to a different bank proceeds in parallel. In the following cycle `bank_en` shows both bank bits, and the read keeps its normal timing.
- R7: When a read's lookup cycle coincides with a write's cycle to the same bank:
  - the write is done first;
  - `rd_busy` is high in that cycle, with only the write's bank enabled;
  - the read looks up in the next cycle, with `rd_done` one cycle later than normal;
  - the read returns the data as updated by the write.
- R8: A refill (`wr_fill`=1) stores the whole line, its tag and a valid bit in the bank's victim way. The victim way comes from a per-bank pointer that is 0 after reset and advances by one, wrapping at 32, on every refill of that bank. The refill is visible to any read accepted in the cycle after the refill request.
- R9: A word write (`wr_fill`=0) replaces the addressed word of the lowest matching valid line in its bank. If no line matches, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request |
| rd_vaddr | input | 32 | Read virtual address (bank and word select) |
| rd_ptag | input | 20 | Physical tag for the read, valid one cycle after the request |
| rd_busy | output | 1 | Read input not accepted this cycle (same-bank stall) |
| rd_done | output | 1 | Read result valid |
| rd_hit | output | 1 | Read hit |
| rd_data | output | 32 | Read word (zero on miss) |
| wr_req | input | 1 | Write request, always accepted |
| wr_fill | input | 1 | 1 = whole-line refill, 0 = word update |
| wr_vaddr | input | 32 | Write virtual address |
| wr_ptag | input | 20 | Physical tag, given with the write request |
| wr_wdata | input | 32 | Word for a word update |
| wr_line | input | 256 | Line for a refill |
| bank_en | output | 16 | Per-bank enable strobes |

## Verification
The assertions take for granted that a requester keeps `rd_req` low, or re-presents the request, while `rd_busy` is high. They also assume `rd_ptag` is held steady from the lookup cycle until `rd_done`.

The stimulus keeps within these assumptions by issuing one read at a time and holding the tag until the result arrives. A read is only paired with a write in directed cases, where the bench predicts the stall.

Random tags come from a small pool, so repeated fills create duplicate matches. Those duplicates exercise the lowest-way rule and the wrap of the victim pointer.

// File: rtl/bgate_pkg.sv
package bgate_pkg;
    localparam int CACHE_BYTES = 16384;
    localparam int BANKS       = 16;
    localparam int LINE_BYTES  = 32;
    localparam int WORD_BITS   = 32;
    localparam int VADDR_BITS  = 32;
    localparam int PTAG_BITS   = 20;

    typedef enum logic {
        WK_WORD = 1'b0,
        WK_LINE = 1'b1
    } wr_kind_e;
endpackage

// File: rtl/bgate_addr_split.sv
module bgate_addr_split #(
    parameter int VA_W     = 32,
    parameter int OFF_W    = 5,
    parameter int BANK_IW  = 4,
    parameter int WORD_LSB = 2,
    parameter int WORD_IW  = 3
) (
    input  logic [VA_W-1:0]    vaddr,
    output logic [BANK_IW-1:0] bank,
    output logic [WORD_IW-1:0] word
);
    logic unused_bits;

    // bank field sits directly above the line offset
    assign bank = vaddr[OFF_W +: BANK_IW];
    assign word = vaddr[WORD_LSB +: WORD_IW];
    assign unused_bits = ^{vaddr[VA_W-1:OFF_W+BANK_IW], vaddr[WORD_LSB-1:0]};
endmodule

// File: rtl/bgate_bank.sv
module bgate_bank #(
    parameter int WAYS   = 32,
    parameter int TAG_W  = 20,
    parameter int WORDS  = 8,
    parameter int WORD_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  logic [TAG_W-1:0]          rd_tag,
    input  logic [$clog2(WORDS)-1:0]  rd_word,
    output logic                      rd_hit,
    output logic [WORD_W-1:0]         rd_data,
    input  logic                      wr_en,
    input  logic                      wr_fill,
    input  logic [TAG_W-1:0]          wr_tag,
    input  logic [$clog2(WORDS)-1:0]  wr_word,
    input  logic [WORD_W-1:0]         wr_wdata,
    input  logic [WORDS*WORD_W-1:0]   wr_line
);
    localparam int LINE_W = WORDS * WORD_W;
    localparam int WAY_IW = $clog2(WAYS);

    typedef struct packed {
        logic [WAYS-1:0]              valid;
        logic [WAYS-1:0][TAG_W-1:0]   tag;
        logic [WAYS-1:0][LINE_W-1:0]  line;
        logic [WAY_IW-1:0]            rr;
    } bank_st_t;

    bank_st_t           st_d, st_q;
    logic               rd_match, wr_match;
    logic [WAY_IW-1:0]  rd_way, wr_way;

    // lowest matching way wins: scan downward so the last hit is the lowest
    always_comb begin
        rd_match = 1'b0;
        rd_way   = '0;
        wr_match = 1'b0;
        wr_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (st_q.valid[w] && st_q.tag[w] == rd_tag) begin
                rd_match = 1'b1;
                rd_way   = WAY_IW'(w);
            end
            if (st_q.valid[w] && st_q.tag[w] == wr_tag) begin
                wr_match = 1'b1;
                wr_way   = WAY_IW'(w);
            end
        end
    end

    assign rd_hit  = rd_en & rd_match;
    assign rd_data = st_q.line[rd_way][rd_word*WORD_W +: WORD_W];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_fill) begin
                st_d.valid[st_q.rr] = 1'b1;
                st_d.tag[st_q.rr]   = wr_tag;
                st_d.line[st_q.rr]  = wr_line;
                st_d.rr             = st_q.rr + 1'b1;
            end else if (wr_match) begin
                st_d.line[wr_way][wr_word*WORD_W +: WORD_W] = wr_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.valid <= '0;
            st_q.rr    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    victim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_fill |=> st_q.rr == WAY_IW'($past(st_q.rr) + 1'b1));

    // R9
    word_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_fill && !wr_match |=> $stable(st_q.line) && $stable(st_q.valid));
endmodule

// File: rtl/bgate_cache.sv
module bgate_cache
    import bgate_pkg::*;
#(
    parameter int CACHE_B = bgate_pkg::CACHE_BYTES,
    parameter int NBANK   = bgate_pkg::BANKS,
    parameter int LINE_B  = bgate_pkg::LINE_BYTES,
    parameter int WORD_W  = bgate_pkg::WORD_BITS,
    parameter int VA_W    = bgate_pkg::VADDR_BITS,
    parameter int TAG_W   = bgate_pkg::PTAG_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_req,
    input  logic [VA_W-1:0]        rd_vaddr,
    input  logic [TAG_W-1:0]       rd_ptag,
    output logic                   rd_busy,
    output logic                   rd_done,
    output logic                   rd_hit,
    output logic [WORD_W-1:0]      rd_data,
    input  logic                   wr_req,
    input  logic                   wr_fill,
    input  logic [VA_W-1:0]        wr_vaddr,
    input  logic [TAG_W-1:0]       wr_ptag,
    input  logic [WORD_W-1:0]      wr_wdata,
    input  logic [LINE_B*8-1:0]    wr_line,
    output logic [NBANK-1:0]       bank_en
);
    localparam int WAYS     = CACHE_B / (NBANK * LINE_B);
    localparam int LINE_W   = LINE_B * 8;
    localparam int WORDS    = LINE_W / WORD_W;
    localparam int BANK_IW  = $clog2(NBANK);
    localparam int WORD_IW  = $clog2(WORDS);
    localparam int OFF_W    = $clog2(LINE_B);
    localparam int WORD_LSB = $clog2(WORD_W / 8);

    typedef struct packed {
        logic                rs_v;
        logic [BANK_IW-1:0]  rs_bank;
        logic [WORD_IW-1:0]  rs_word;
        logic                ws_v;
        wr_kind_e            ws_kind;
        logic [BANK_IW-1:0]  ws_bank;
        logic [WORD_IW-1:0]  ws_word;
        logic [TAG_W-1:0]    ws_tag;
        logic [WORD_W-1:0]   ws_wdata;
        logic [LINE_W-1:0]   ws_line;
        logic                done;
        logic                hit;
        logic [WORD_W-1:0]   data;
    } pipe_st_t;

    pipe_st_t                      st_d, st_q;
    logic [BANK_IW-1:0]            rq_bank, wq_bank;
    logic [WORD_IW-1:0]            rq_word, wq_word;
    logic                          clash;
    logic [NBANK-1:0]              rd_en_v, wr_en_v, hit_v;
    logic [NBANK-1:0][WORD_W-1:0]  data_v;

    // step one: bank decode from the virtual address
    bgate_addr_split #(.VA_W(VA_W), .OFF_W(OFF_W), .BANK_IW(BANK_IW),
                       .WORD_LSB(WORD_LSB), .WORD_IW(WORD_IW)) u_rsplit (
        .vaddr(rd_vaddr), .bank(rq_bank), .word(rq_word));

    bgate_addr_split #(.VA_W(VA_W), .OFF_W(OFF_W), .BANK_IW(BANK_IW),
                       .WORD_LSB(WORD_LSB), .WORD_IW(WORD_IW)) u_wsplit (
        .vaddr(wr_vaddr), .bank(wq_bank), .word(wq_word));

    // step two: only the decoded banks are switched on
    always_comb begin
        clash = st_q.rs_v && st_q.ws_v && (st_q.rs_bank == st_q.ws_bank);
        for (int b = 0; b < NBANK; b++) begin
            rd_en_v[b] = st_q.rs_v && !clash && (st_q.rs_bank == BANK_IW'(b));
            wr_en_v[b] = st_q.ws_v && (st_q.ws_bank == BANK_IW'(b));
        end
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        bgate_bank #(.WAYS(WAYS), .TAG_W(TAG_W), .WORDS(WORDS), .WORD_W(WORD_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_en    (rd_en_v[g]),
            .rd_tag   (rd_ptag),
            .rd_word  (st_q.rs_word),
            .rd_hit   (hit_v[g]),
            .rd_data  (data_v[g]),
            .wr_en    (wr_en_v[g]),
            .wr_fill  (st_q.ws_kind == WK_LINE),
            .wr_tag   (st_q.ws_tag),
            .wr_word  (st_q.ws_word),
            .wr_wdata (st_q.ws_wdata),
            .wr_line  (st_q.ws_line)
        );
    end

    always_comb begin
        st_d = st_q;
        // read decode stage holds while the write owns its bank
        if (!clash) begin
            st_d.rs_v    = rd_req;
            st_d.rs_bank = rq_bank;
            st_d.rs_word = rq_word;
        end
        st_d.ws_v     = wr_req;
        st_d.ws_kind  = wr_fill ? WK_LINE : WK_WORD;
        st_d.ws_bank  = wq_bank;
        st_d.ws_word  = wq_word;
        st_d.ws_tag   = wr_ptag;
        st_d.ws_wdata = wr_wdata;
        st_d.ws_line  = wr_line;
        st_d.done     = st_q.rs_v && !clash;
        st_d.hit      = hit_v[st_q.rs_bank] && st_d.done;
        st_d.data     = st_d.hit ? data_v[st_q.rs_bank] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_busy = clash;
    assign rd_done = st_q.done;
    assign rd_hit  = st_q.hit;
    assign rd_data = st_q.data;
    assign bank_en = rd_en_v | wr_en_v;

    // R3
    lookup_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> $past(|bank_en));

    // R7
    stall_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy |=> !rd_done);

    // R7
    done_not_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> !$past(rd_busy));

    // R5
    strobe_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy |-> $countones(bank_en) == 1);
endmodule

// File: tb/sim_bgate_cache.sv
`timescale 1ns/1ps
module sim_bgate_cache;
    localparam int NB = 16, NW = 32, LW = 256;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rd_req = 0, rd_busy, rd_done, rd_hit;
    logic [31:0] rd_vaddr = 0, rd_data;
    logic [19:0] rd_ptag = 0;
    logic wr_req = 0, wr_fill = 0;
    logic [31:0] wr_vaddr = 0, wr_wdata = 0;
    logic [19:0] wr_ptag = 0;
    logic [LW-1:0] wr_line = 0;
    logic [NB-1:0] bank_en;

    int compared = 0, mismatched = 0;

    bit [19:0]     mtag  [NB][NW];
    bit            mval  [NB][NW];
    logic [LW-1:0] mline [NB][NW];
    int            mrr   [NB];

    bgate_cache u0 (.*);

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit mfind(input int b, input bit [19:0] t, output int way);
        way = 0;
        for (int w = 0; w < NW; w++)
            if (mval[b][w] && mtag[b][w] == t) begin way = w; return 1'b1; end
        return 1'b0;
    endfunction

    function automatic logic [31:0] mkaddr(input int b, input int w);
        logic [31:0] a = $urandom;
        a[8:5] = b[3:0];
        a[4:2] = w[2:0];
        return a;
    endfunction

    function automatic logic [LW-1:0] rline();
        logic [LW-1:0] l;
        for (int i = 0; i < 8; i++) l[i*32 +: 32] = $urandom;
        return l;
    endfunction

    function automatic void mwrite(input int b, input bit fill, input bit [19:0] t,
                                   input int w, input logic [31:0] d, input logic [LW-1:0] l);
        int way;
        if (fill) begin
            mval[b][mrr[b]] = 1; mtag[b][mrr[b]] = t; mline[b][mrr[b]] = l;
            mrr[b] = (mrr[b] + 1) % NW;
        end else if (mfind(b, t, way)) begin
            mline[b][way][w*32 +: 32] = d;
        end
    endfunction

    task automatic exp_read(input int b, input int w, input bit [19:0] t,
                            output bit eh, output logic [31:0] ed);
        int way;
        eh = mfind(b, t, way);
        ed = eh ? mline[b][way][w*32 +: 32] : 32'h0;
    endtask

    task automatic do_read(input int b, input int w, input bit [19:0] t, input string req);
        bit eh; logic [31:0] ed;
        @(negedge clk);
        rd_req = 1; rd_vaddr = mkaddr(b, w); rd_ptag = t;
        @(negedge clk);
        rd_req = 0;
        chk(bank_en == NB'(1 << b), "R2/R5 read strobe", 64'(bank_en), 64'(1 << b));
        chk(rd_done == 0, "R3 no early done", 64'(rd_done), 0);
        @(negedge clk);
        exp_read(b, w, t, eh, ed);
        chk(rd_done == 1, "R3 done", 64'(rd_done), 1);
        chk(rd_hit == eh, {req, " hit"}, 64'(rd_hit), 64'(eh));
        chk(rd_data == ed, {req, " data"}, 64'(rd_data), 64'(ed));
    endtask

    task automatic do_write(input int b, input bit fill, input bit [19:0] t, input int w,
                            input logic [31:0] d, input logic [LW-1:0] l);
        @(negedge clk);
        wr_req = 1; wr_fill = fill; wr_vaddr = mkaddr(b, w); wr_ptag = t;
        wr_wdata = d; wr_line = l;
        @(negedge clk);
        wr_req = 0;
        chk(bank_en == NB'(1 << b), fill ? "R8 fill strobe" : "R9 write strobe",
            64'(bank_en), 64'(1 << b));
        mwrite(b, fill, t, w, d, l);
    endtask

    task automatic do_pair(input int rb, input int rw, input bit [19:0] rt,
                           input int wb, input int ww, input bit [19:0] wt, input logic [31:0] d);
        bit eh; logic [31:0] ed;
        @(negedge clk);
        rd_req = 1; rd_vaddr = mkaddr(rb, rw); rd_ptag = rt;
        wr_req = 1; wr_fill = 0; wr_vaddr = mkaddr(wb, ww); wr_ptag = wt; wr_wdata = d;
        @(negedge clk);
        rd_req = 0; wr_req = 0;
        if (rb != wb) begin
            chk(bank_en == NB'((1 << rb) | (1 << wb)), "R6 two strobes",
                64'(bank_en), 64'((1 << rb) | (1 << wb)));
            chk(rd_busy == 0, "R6 no stall", 64'(rd_busy), 0);
            mwrite(wb, 0, wt, ww, d, '0);
            @(negedge clk);
            exp_read(rb, rw, rt, eh, ed);
            chk(rd_done == 1, "R6 done", 64'(rd_done), 1);
            chk(rd_data == ed, "R6 data", 64'(rd_data), 64'(ed));
        end else begin
            chk(rd_busy == 1, "R7 stall", 64'(rd_busy), 1);
            chk(bank_en == NB'(1 << wb), "R7 write strobe only", 64'(bank_en), 64'(1 << wb));
            mwrite(wb, 0, wt, ww, d, '0);
            @(negedge clk);
            chk(rd_busy == 0, "R7 stall over", 64'(rd_busy), 0);
            chk(rd_done == 0, "R7 done delayed", 64'(rd_done), 0);
            chk(bank_en == NB'(1 << rb), "R7 read strobe", 64'(bank_en), 64'(1 << rb));
            @(negedge clk);
            exp_read(rb, rw, rt, eh, ed);
            chk(rd_done == 1, "R7 done", 64'(rd_done), 1);
            chk(rd_data == ed, "R7 data after write", 64'(rd_data), 64'(ed));
        end
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int b = 0; b < NB; b++) begin
            mrr[b] = 0;
            for (int w = 0; w < NW; w++) begin mval[b][w] = 0; mtag[b][w] = 0; mline[b][w] = '0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 idle state after reset
        chk(bank_en == 0, "R1 idle strobes", 64'(bank_en), 0);
        chk(rd_busy == 0 && rd_done == 0, "R1 idle flags", 64'({rd_busy, rd_done}), 0);
        do_read(4, 1, 20'h0, "R1 empty read");
        do_read(11, 7, 20'h12345, "R1 empty read");

        // R8 fill then hit, R2 field positions
        do_write(9, 1, 20'hABCDE, 0, 0, rline());
        do_read(9, 5, 20'hABCDE, "R4 hit after fill");
        do_read(8, 5, 20'hABCDE, "R2 other bank misses");

        // R8 victim pointer wraps after 32 refills
        for (int i = 0; i < 33; i++) do_write(3, 1, 20'(100 + i), 0, 0, rline());
        do_read(3, 0, 20'd100, "R8 evicted tag misses");
        do_read(3, 6, 20'd101, "R8 surviving tag hits");
        do_read(3, 2, 20'd132, "R8 wrapped slot hits");

        // R4 duplicate tags: lowest way supplies data
        do_write(7, 1, 20'd50, 0, 0, rline());
        do_write(7, 1, 20'd50, 0, 0, rline());
        do_read(7, 3, 20'd50, "R4 lowest way");

        // R9 word write hit and miss
        do_write(7, 0, 20'd50, 3, 32'hDEAD_BEEF, '0);
        do_read(7, 3, 20'd50, "R9 word updated");
        do_write(7, 0, 20'd999, 4, 32'h1111_2222, '0);
        do_read(7, 4, 20'd50, "R9 miss write no effect");

        // R6 and R7 concurrency
        do_pair(9, 2, 20'hABCDE, 7, 3, 20'd50, 32'hCAFE_0001);
        do_pair(7, 3, 20'd50, 7, 3, 20'd50, 32'hCAFE_0002);
        do_pair(3, 6, 20'd101, 3, 6, 20'd101, 32'h0BAD_F00D);

        // constrained random traffic over a small tag pool
        for (int n = 0; n < 600; n++) begin
            int op = $urandom % 6;
            int b  = $urandom % NB;
            int w  = $urandom % 8;
            bit [19:0] t = 20'($urandom % 12);
            case (op)
                0:       do_write(b, 1, t, w, 0, rline());
                1:       do_write(b, 0, t, w, $urandom, '0);
                2:       do_pair(b, w, t, $urandom % NB, $urandom % 8, 20'($urandom % 12), $urandom);
                default: do_read(b, w, t, "R4 random read");
            endcase
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule